// File: doc/BRIEF.md
# Fixed-Point Iterative ODE Stepper

This block integrates a second-order differential equation numerically with a forward step of fixed size. A one-cycle start request captures the operands: the running coordinate, the solution value, its derivative, the step size and the upper bound of the interval. The block then repeats one update step until the advanced coordinate is no longer below the bound. Finally it presents the last solution value together with a one-cycle completion pulse.

Each step is spread over four clock cycles. Two fixed-point multipliers and one adder/subtractor are shared across those cycles. All arithmetic is signed Q8.8 in 16 bits: sums wrap modulo 2^16, and products keep the low 16 bits of the 32-bit product after an arithmetic right shift by 8. The loop body always runs at least once, even when the starting coordinate already lies at or beyond the bound. A host can start a computation whenever the block reports that it is not busy, and then waits for the completion pulse.

Top module: `ode_solver`

## Requirements
- R1: A synchronous active-high reset returns the block to idle, with busy, done and yOut all 0. This also holds when reset arrives in the middle of a computation, and no done pulse follows such a reset.
- R2: Let fm(p,q) be the low 16 bits of (p*q) >>> 8, computed on the 32-bit signed product. One step uses the old values of x, y, u, dx to form ud = fm(u,dx), yd = fm(y,dx) and xud = fm(x,ud). It then sets x' = x+dx, y' = y+ud and u' = u - 3*yd - 3*xud, all taken modulo 2^16. All three variables are replaced together at the end of the step.
- R3: After a step, the loop continues only when the new x is strictly less than a, compared as signed numbers. The body always executes at least once, so N, the number of steps, is at least 1.
- R4: Each step takes exactly 4 cycles. busy rises in the first cycle after the accepting clock edge and stays high for exactly 4*N consecutive cycles.
- R5: done is high for exactly one cycle, which is the first cycle in which busy is low again. In that cycle yOut holds the final y. yOut keeps that value until the next completion or a reset.
- R6: A start request made while busy is high has no effect on the result or on the step count of the computation in progress.
- R7: A start request while idle captures xIn, yIn, uIn, dxIn and aIn on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to capture the operands and begin |
| xIn | input | 16 | Starting coordinate, Q8.8 signed |
| yIn | input | 16 | Starting solution value, Q8.8 signed |
| uIn | input | 16 | Starting derivative, Q8.8 signed |
| dxIn | input | 16 | Step size, Q8.8 signed |
| aIn | input | 16 | Interval bound, Q8.8 signed |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle completion pulse |
| yOut | output | 16 | Final solution value, Q8.8 signed |

## Verification
A wrong phase selection or a bad operand mux corrupts an intermediate product. That error reaches yOut only when the run finishes, so the bench compares every final value against an arithmetic model. The bench sweeps start points, interval spans (including bounds at or below the start), step sizes and initial values. A fault in the exit comparison or in the phase sequencing changes the busy length. That shows up at the ports one cycle after the last step, as a busy count that is not 4*N.

// File: rtl/ode_pkg.sv
package ode_pkg;

  // One-hot phase strobes issued by the control to the datapath.
  typedef struct packed {
    logic load;
    logic ph1;
    logic ph2;
    logic ph3;
    logic ph4;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P1,
    ST_P2,
    ST_P3,
    ST_P4
  } ctrlState_t;

endpackage

// File: rtl/ode_fxmul.sv
module ode_fxmul #(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] opB,
  output logic signed [W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] wide;

  assign wide = PW'(opA) * PW'(opB);
  assign prod = W'(wide >>> F);
endmodule

// File: rtl/ode_addsub.sv
module ode_addsub #(
  parameter int W = 16
) (
  input  logic              doSub,
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] opB,
  output logic signed [W-1:0] res
);
  assign res = doSub ? (opA - opB) : (opA + opB);
endmodule

// File: rtl/ode_dpath.sv
module ode_dpath
  import ode_pkg::*;
#(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  input  logic signed [W-1:0] uIn,
  input  logic signed [W-1:0] dxIn,
  input  logic signed [W-1:0] aIn,
  output logic              contOut,
  output logic signed [W-1:0] yRes
);
  localparam int NUM_MUL = 2;
  localparam logic signed [W-1:0] kThree = W'(3 << F);

  logic signed [W-1:0] xR, yR, uR, dxR, aR;
  logic signed [W-1:0] udR, ydR, xnR, xudR, yd3R, ynR, xud3R, tmpR;

  logic signed [W-1:0] mulA [NUM_MUL];
  logic signed [W-1:0] mulB [NUM_MUL];
  logic signed [W-1:0] mulP [NUM_MUL];
  logic signed [W-1:0] aluA, aluB, aluRes;
  logic                aluSub;

  genvar g;
  generate
    for (g = 0; g < NUM_MUL; g++) begin : gMul
      ode_fxmul #(.W(W), .F(F)) u_mul (
        .opA (mulA[g]),
        .opB (mulB[g]),
        .prod(mulP[g])
      );
    end
  endgenerate

  ode_addsub #(.W(W)) u_alu (
    .doSub(aluSub),
    .opA  (aluA),
    .opB  (aluB),
    .res  (aluRes)
  );

  // Operand steering per phase; phase 2 is the default routing.
  always_comb begin
    mulA[0] = xR;
    mulB[0] = udR;
    mulA[1] = kThree;
    mulB[1] = ydR;
    aluA    = yR;
    aluB    = udR;
    aluSub  = 1'b0;
    if (strobe.ph1) begin
      mulA[0] = uR;
      mulB[0] = dxR;
      mulA[1] = yR;
      mulB[1] = dxR;
      aluA    = xR;
      aluB    = dxR;
    end else if (strobe.ph3) begin
      mulA[0] = kThree;
      mulB[0] = xudR;
      aluA    = uR;
      aluB    = yd3R;
      aluSub  = 1'b1;
    end else if (strobe.ph4) begin
      aluA    = tmpR;
      aluB    = xud3R;
      aluSub  = 1'b1;
    end
  end

  assign contOut = (xnR < aR);

  always_ff @(posedge clk) begin
    if (rst) begin
      xR    <= '0;
      yR    <= '0;
      uR    <= '0;
      dxR   <= '0;
      aR    <= '0;
      udR   <= '0;
      ydR   <= '0;
      xnR   <= '0;
      xudR  <= '0;
      yd3R  <= '0;
      ynR   <= '0;
      xud3R <= '0;
      tmpR  <= '0;
      yRes  <= '0;
    end else begin
      if (strobe.load) begin
        xR  <= xIn;
        yR  <= yIn;
        uR  <= uIn;
        dxR <= dxIn;
        aR  <= aIn;
      end
      if (strobe.ph1) begin
        udR <= mulP[0];
        ydR <= mulP[1];
        xnR <= aluRes;
      end
      if (strobe.ph2) begin
        xudR <= mulP[0];
        yd3R <= mulP[1];
        ynR  <= aluRes;
      end
      if (strobe.ph3) begin
        xud3R <= mulP[0];
        tmpR  <= aluRes;
      end
      if (strobe.ph4) begin
        xR <= xnR;
        yR <= ynR;
        uR <= aluRes;
        if (!contOut) begin
          yRes <= ynR;
        end
      end
    end
  end
endmodule

// File: rtl/ode_ctrl.sv
module ode_ctrl
  import ode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      contIn,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_P1;
      ST_P1:   stateNext = ST_P2;
      ST_P2:   stateNext = ST_P3;
      ST_P3:   stateNext = ST_P4;
      ST_P4:   stateNext = contIn ? ST_P1 : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.ph1  = (state == ST_P1);
    strobe.ph2  = (state == ST_P2);
    strobe.ph3  = (state == ST_P3);
    strobe.ph4  = (state == ST_P4);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_P4) && !contIn;
    end
  end
endmodule

// File: rtl/ode_solver.sv
module ode_solver #(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  input  logic signed [W-1:0] uIn,
  input  logic signed [W-1:0] dxIn,
  input  logic signed [W-1:0] aIn,
  output logic              busy,
  output logic              done,
  output logic signed [W-1:0] yOut
);
  ode_pkg::dpStrobe_t strobe;
  logic               cont;

  ode_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .contIn(cont),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  ode_dpath #(.W(W), .F(F)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .xIn    (xIn),
    .yIn    (yIn),
    .uIn    (uIn),
    .dxIn   (dxIn),
    .aIn    (aIn),
    .contOut(cont),
    .yRes   (yOut)
  );
endmodule

// File: rtl/ode_solver_chk.sv
module ode_solver_chk #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic signed [W-1:0] yOut
);
  int busyLen;

  always_ff @(posedge clk) begin
    if (rst)       busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_yout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(yOut));

  p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_iter_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ((busyLen % 4) == 0 && busyLen >= 4));

  p_busy_nodone_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
endmodule

bind ode_solver ode_solver_chk #(.W(W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .busy (busy),
  .done (done),
  .yOut (yOut)
);

// File: tb/ode_solver_tb.sv
module ode_solver_tb;
  localparam int PERIOD = 10;
  localparam int RUN_LIMIT = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [15:0] xIn = '0, yIn = '0, uIn = '0, dxIn = '0, aIn = '0;
  logic busy, done;
  logic signed [15:0] yOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  ode_solver u_dut (
    .clk(clk), .rst(rst), .start(start),
    .xIn(xIn), .yIn(yIn), .uIn(uIn), .dxIn(dxIn), .aIn(aIn),
    .busy(busy), .done(done), .yOut(yOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] fm(input logic signed [15:0] p, input logic signed [15:0] q);
    logic signed [31:0] w;
    w = 32'(p) * 32'(q);
    return 16'(w >>> 8);
  endfunction

  // Arithmetic model of the recurrence (R2, R3)
  function automatic void model(input logic signed [15:0] x0, y0, u0, dx, a,
                                output logic signed [15:0] yf, output int n);
    logic signed [15:0] x, y, u, xn, ud, yd, xud;
    x = x0; y = y0; u = u0; n = 0;
    do begin
      xn  = x + dx;
      ud  = fm(u, dx);
      yd  = fm(y, dx);
      xud = fm(x, ud);
      u   = u - 16'(3 * yd) - 16'(3 * xud);
      y   = y + ud;
      x   = xn;
      n++;
    end while (xn < a && n < RUN_LIMIT);
    yf = y;
  endfunction

  task automatic runCase(input logic signed [15:0] x0, y0, u0, dx, a, input bit inject);
    logic signed [15:0] expY;
    int expN, cyc;
    model(x0, y0, u0, dx, a, expY, expN);
    @(negedge clk);
    xIn = x0; yIn = y0; uIn = u0; dxIn = dx; aIn = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after accepted start", int'(busy), 1);
    cyc = 0;
    while (busy === 1'b1 && cyc < RUN_LIMIT) begin
      cyc++;
      if (inject && cyc == 2) begin
        start = 1'b1;
        xIn = x0 - 16'sd512; yIn = y0 + 16'sd77; uIn = -u0; dxIn = 16'sd1; aIn = 16'sh7F00;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == 4 * expN, inject ? "R6 R3 R4 step count with ignored start" : "R3 R4 busy length",
        cyc, 4 * expN);
    chk(done === 1'b1, "R5 done when busy falls", int'(done), 1);
    chk(yOut === expY, inject ? "R6 R2 result with ignored start" : "R2 final y",
        int'(yOut), int'(expY));
    @(negedge clk);
    chk(done === 1'b0, "R5 done single cycle", int'(done), 0);
    chk(yOut === expY, "R5 yOut held", int'(yOut), int'(expY));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic signed [15:0] XS [3] = '{-16'sd512, 16'sd0, 16'sd384};
  localparam logic signed [15:0] SPANS [4] = '{-16'sd256, 16'sd0, 16'sd100, 16'sd2560};
  localparam logic signed [15:0] DXS [3] = '{16'sd16, 16'sd64, 16'sd256};
  localparam logic signed [15:0] US [3] = '{16'sd0, 16'sd256, 16'sd1280};
  localparam logic signed [15:0] YS [3] = '{16'sd256, -16'sd128, 16'sd3000};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R1 done after reset", int'(done), 0);
    chk(yOut === 16'sd0, "R1 yOut after reset", int'(yOut), 0);

    // Sweep start points, spans (bound below / at / above start), steps, initial values
    for (int ix = 0; ix < 3; ix++)
      for (int is = 0; is < 4; is++)
        for (int id = 0; id < 3; id++)
          for (int iv = 0; iv < 3; iv++)
            runCase(XS[ix], YS[iv], US[iv], DXS[id], XS[ix] + SPANS[is], 1'b0);

    // R6: start requests during busy
    runCase(16'sd0, 16'sd256, 16'sd256, 16'sd64, 16'sd1024, 1'b1);
    runCase(-16'sd300, 16'sd3000, 16'sd1280, 16'sd16, 16'sd200, 1'b1);

    // R1: reset in the middle of a run
    @(negedge clk);
    xIn = 16'sd0; yIn = 16'sd256; uIn = 16'sd256; dxIn = 16'sd16; aIn = 16'sd2560; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R1 busy after mid-run reset", int'(busy), 0);
    chk(yOut === 16'sd0, "R1 yOut after mid-run reset", int'(yOut), 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R1 no done after abort", int'(done), 0);
    end

    // R7: fresh operands captured after the abort
    runCase(16'sd256, -16'sd128, 16'sd0, 16'sd256, 16'sd1024, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule